// File: doc/BRIEF.md
# Region Protection Checker

This block classifies each memory access against a small table of protection regions. Every region has a naturally aligned base, a power-of-two size, a valid flag and six permission bits, split into read, write and execute for privileged code and for unprivileged code. An access presents an address, an access kind (instruction fetch, data read or data write) and a privilege flag. One clock edge later the block reports one of four outcomes: allowed, no matching region, more than one matching region, or permission failure.

Misses and permission failures are reported on separate strobes for the instruction side and the data side, so the core can raise the matching exception. A multiple match gets its own strobe and takes precedence over any permission result. A global enable input switches checking off, and every access is then allowed. The region table is loaded one entry at a time through a write port that uses an index. Address translation, caching and exception vectoring are handled elsewhere.

Top module: `region_guard`

## Requirements
- R1: After reset no region is valid, `res_valid` is 0 and all five strobes are 0.
- R2: `res_valid` and the result fields appear in the cycle after the edge that sampled `acc_req` = 1. With no request, `res_valid` is 0, `res_code` is 0 and no strobe is set.
- R3: When checking is enabled and no valid region contains the address, `res_code` = 1 (miss). A fetch (`acc_type` = 0) raises `ins_miss`, and a read or write raises `dat_miss`.
- R4: When two or more valid regions contain the address, `res_code` = 2 and `multi_hit` is raised, whatever the permissions of those regions.
- R5: When exactly one valid region contains the address and its permission bit for the access grants it, `res_code` = 0 and no strobe is set.
- R6: When exactly one valid region contains the address and its permission bit denies the access, `res_code` = 3. A fetch raises `ins_prot`, and a read or write raises `dat_prot`.
- R7: Permission layout: `cfg_perm[0]` = privileged read, `[1]` = privileged write, `[2]` = privileged execute, `[3]` = unprivileged read, `[4]` = unprivileged write, `[5]` = unprivileged execute. `acc_type` 0 = fetch (uses execute), 1 = read, 2 = write, 3 = read.
- R8: `cfg_size` is log2 of the region size in bytes. Values below 12 are stored as 12 and values above 32 as 32. The base is stored with its low `size` bits cleared, and an address matches when its bits above `size` equal the stored base.
- R9: When `chk_en` = 0, every request returns `res_code` = 0 with no strobe.
- R10: An entry written with `cfg_valid` = 0 never matches.
- R11: A write to entry `cfg_idx` replaces that entry only, and it applies to requests sampled from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Global checking enable |
| cfg_we | input | 1 | Region entry write strobe |
| cfg_idx | input | 3 | Entry index to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 6 | log2 of the region size |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_perm | input | 6 | Permission bits (layout in R7) |
| acc_req | input | 1 | Access request |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| acc_priv | input | 1 | 1 = privileged access |
| res_valid | output | 1 | Result valid |
| res_code | output | 2 | 0 ok, 1 miss, 2 multiple hit, 3 violation |
| ins_miss | output | 1 | Instruction-side miss strobe |
| ins_prot | output | 1 | Instruction-side protection strobe |
| dat_miss | output | 1 | Data-side miss strobe |
| dat_prot | output | 1 | Data-side protection strobe |
| multi_hit | output | 1 | Multiple-hit strobe |

## Verification
Every outcome is due exactly one edge after the request is sampled. The bench drives each request on a falling edge and reads the result fields and strobes on the next falling edge, half a cycle after the registering edge. A table write becomes visible at the edge that captures it, so the bench issues each request at least one cycle after the last write. Idle cycles are sampled the same way to confirm that nothing stays asserted from the previous request.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

   typedef enum logic [1:0] {
      RES_OK    = 2'd0,
      RES_MISS  = 2'd1,
      RES_MULTI = 2'd2,
      RES_VIOL  = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_ALT   = 2'd3
   } acc_e;

   localparam int PERM_W = 6;

   // Bits [2:0] serve privileged code and [5:3] unprivileged code (R7).
   // Inside each group: bit 0 read, bit 1 write, bit 2 execute.
   function automatic logic perm_grant(input logic [PERM_W-1:0] p,
                                       input logic priv,
                                       input logic [1:0] kind);
      logic [2:0] grp;
      grp = priv ? p[2:0] : p[5:3];
      case (kind)
         ACC_FETCH: perm_grant = grp[2];
         ACC_WRITE: perm_grant = grp[1];
         default:   perm_grant = grp[0];
      endcase
   endfunction

endpackage

// File: rtl/region_guard_entry.sv
module region_guard_entry
   import region_guard_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SZ_W     = 6,
   parameter int MIN_LOG2 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [SZ_W-1:0]   wr_size,
   input  logic              wr_valid,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_priv,
   input  logic [1:0]        acc_type,
   output logic              hit,
   output logic              allow
);

   localparam int MAX_LOG2 = ADDR_W;

   logic              valid_q;
   logic [ADDR_W-1:0] base_q;
   logic [SZ_W-1:0]   size_q;
   logic [PERM_W-1:0] perm_q;

   logic [SZ_W-1:0]   size_c;
   logic [ADDR_W-1:0] wr_low;
   logic [ADDR_W-1:0] cmp_mask;

   // Clamp the size field to its legal range (R8).
   always_comb begin
      if (int'(wr_size) < MIN_LOG2)      size_c = SZ_W'(MIN_LOG2);
      else if (int'(wr_size) > MAX_LOG2) size_c = SZ_W'(MAX_LOG2);
      else                               size_c = wr_size;
   end

   // Offset bits that are cleared from the base on a write.
   always_comb begin
      for (int b = 0; b < ADDR_W; b++)
         wr_low[b] = (b < int'(size_c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         base_q  <= '0;
         size_q  <= SZ_W'(MIN_LOG2);
         perm_q  <= '0;
      end else if (wr_en) begin
         valid_q <= wr_valid;
         base_q  <= wr_base & ~wr_low;
         size_q  <= size_c;
         perm_q  <= wr_perm;
      end
   end

   // Compare mask for the stored region: only bits above the size take part.
   always_comb begin
      for (int b = 0; b < ADDR_W; b++)
         cmp_mask[b] = (b >= int'(size_q));
   end

   assign hit   = valid_q && (((acc_addr ^ base_q) & cmp_mask) == '0);
   assign allow = perm_grant(perm_q, acc_priv, acc_type);

endmodule

// File: rtl/region_guard_resolve.sv
module region_guard_resolve
   import region_guard_pkg::*;
#(
   parameter int N_ENT = 8
) (
   input  logic             chk_en,
   input  logic [N_ENT-1:0] hit_vec,
   input  logic [N_ENT-1:0] allow_vec,
   output res_e             code
);

   logic any_hit;
   logic many_hit;
   logic granted;

   assign any_hit  = |hit_vec;
   // Clearing the lowest set bit leaves a remainder only if two or more hits exist.
   assign many_hit = |(hit_vec & (hit_vec - N_ENT'(1)));
   assign granted  = |(hit_vec & allow_vec);

   // Precedence: disabled, miss, multiple hit, then the permission result.
   always_comb begin
      if (!chk_en)       code = RES_OK;
      else if (!any_hit) code = RES_MISS;
      else if (many_hit) code = RES_MULTI;
      else if (!granted) code = RES_VIOL;
      else               code = RES_OK;
   end

endmodule

// File: rtl/region_guard.sv
module region_guard
   import region_guard_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int N_ENT    = 8,
   parameter int MIN_LOG2 = 12,
   parameter int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   parameter int SZ_W     = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SZ_W-1:0]   cfg_size,
   input  logic              cfg_valid,
   input  logic [5:0]        cfg_perm,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_type,
   input  logic              acc_priv,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic              ins_miss,
   output logic              ins_prot,
   output logic              dat_miss,
   output logic              dat_prot,
   output logic              multi_hit
);

   if (N_ENT < 2 || N_ENT > 64) begin : g_bad_n
      $error("region_guard: N_ENT must lie in 2..64");
   end
   if (MIN_LOG2 < 1 || MIN_LOG2 > ADDR_W) begin : g_bad_min
      $error("region_guard: MIN_LOG2 must lie in 1..ADDR_W");
   end
   if ((1 << IDX_W) < N_ENT) begin : g_bad_idx
      $error("region_guard: IDX_W too narrow for N_ENT");
   end

   logic [N_ENT-1:0] hit_vec;
   logic [N_ENT-1:0] allow_vec;
   res_e             code_c;

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      region_guard_entry #(
         .ADDR_W  (ADDR_W),
         .SZ_W    (SZ_W),
         .MIN_LOG2(MIN_LOG2)
      ) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && (cfg_idx == IDX_W'(e))),
         .wr_base (cfg_base),
         .wr_size (cfg_size),
         .wr_valid(cfg_valid),
         .wr_perm (cfg_perm),
         .acc_addr(acc_addr),
         .acc_priv(acc_priv),
         .acc_type(acc_type),
         .hit     (hit_vec[e]),
         .allow   (allow_vec[e])
      );
   end

   region_guard_resolve #(.N_ENT(N_ENT)) u_resolve (
      .chk_en   (chk_en),
      .hit_vec  (hit_vec),
      .allow_vec(allow_vec),
      .code     (code_c)
   );

   logic is_fetch;
   assign is_fetch = (acc_type == ACC_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= RES_OK;
         ins_miss  <= 1'b0;
         ins_prot  <= 1'b0;
         dat_miss  <= 1'b0;
         dat_prot  <= 1'b0;
         multi_hit <= 1'b0;
      end else begin
         res_valid <= acc_req;
         res_code  <= acc_req ? code_c : RES_OK;
         ins_miss  <= acc_req &&  is_fetch && (code_c == RES_MISS);
         dat_miss  <= acc_req && !is_fetch && (code_c == RES_MISS);
         ins_prot  <= acc_req &&  is_fetch && (code_c == RES_VIOL);
         dat_prot  <= acc_req && !is_fetch && (code_c == RES_VIOL);
         multi_hit <= acc_req && (code_c == RES_MULTI);
      end
   end

endmodule

// File: rtl/region_guard_sva.sv
module region_guard_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       chk_en,
   input logic       acc_req,
   input logic [1:0] acc_type,
   input logic       res_valid,
   input logic [1:0] res_code,
   input logic       ins_miss,
   input logic       ins_prot,
   input logic       dat_miss,
   input logic       dat_prot,
   input logic       multi_hit
);

   logic [4:0] strobes;
   assign strobes = {multi_hit, ins_miss, ins_prot, dat_miss, dat_prot};

   a_r2_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |=> res_valid);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> (!res_valid && res_code == 2'd0 && strobes == 5'd0));

   a_r9_disabled_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !chk_en) |=> (res_code == 2'd0 && strobes == 5'd0));

   a_r3_fetch_no_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_type == 2'd0) |=> (!dat_miss && !dat_prot));

   a_r6_data_no_ins_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_type != 2'd0) |=> (!ins_miss && !ins_prot));

   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));

   a_r3_miss_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd1) |-> (ins_miss || dat_miss));

   a_r5_ok_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (res_code == 2'd0) |-> (strobes == 5'd0));

endmodule

bind region_guard region_guard_sva u_region_guard_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .chk_en   (chk_en),
   .acc_req  (acc_req),
   .acc_type (acc_type),
   .res_valid(res_valid),
   .res_code (res_code),
   .ins_miss (ins_miss),
   .ins_prot (ins_prot),
   .dat_miss (dat_miss),
   .dat_prot (dat_prot),
   .multi_hit(multi_hit)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_en = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_base = '0;
   logic [5:0]  cfg_size = '0;
   logic        cfg_valid = 1'b0;
   logic [5:0]  cfg_perm = '0;
   logic        acc_req = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_type = '0;
   logic        acc_priv = 1'b0;
   logic        res_valid, ins_miss, ins_prot, dat_miss, dat_prot, multi_hit;
   logic [1:0]  res_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   region_guard u_region_guard (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
      .acc_req(acc_req), .acc_addr(acc_addr), .acc_type(acc_type),
      .acc_priv(acc_priv), .res_valid(res_valid), .res_code(res_code),
      .ins_miss(ins_miss), .ins_prot(ins_prot), .dat_miss(dat_miss),
      .dat_prot(dat_prot), .multi_hit(multi_hit)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bench-side model of the region table.
   bit          m_valid [NE];
   logic [31:0] m_base  [NE];
   int          m_size  [NE];
   logic [5:0]  m_perm  [NE];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_code(input logic [31:0] a, input logic [1:0] t,
                                     input logic priv);
      int n = 0;
      int which = 0;
      logic [2:0] g;
      bit ok;
      if (!chk_en) return 0;
      for (int e = 0; e < NE; e++) begin
         logic [63:0] mk;
         mk = ~((64'd1 << m_size[e]) - 64'd1);
         if (m_valid[e] && (((a ^ m_base[e]) & mk[31:0]) == 32'd0)) begin
            n++;
            which = e;
         end
      end
      if (n == 0) return 1;
      if (n > 1) return 2;
      g = priv ? m_perm[which][2:0] : m_perm[which][5:3];
      ok = (t == 2'd0) ? g[2] : (t == 2'd2) ? g[1] : g[0];
      return ok ? 0 : 3;
   endfunction

   task automatic wr_entry(input int idx, input logic [31:0] b, input int sz,
                           input bit v, input logic [5:0] p);
      int szc;
      logic [63:0] lo;
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_size = 6'(sz);
      cfg_valid = v; cfg_perm = p;
      @(negedge clk);
      cfg_we = 1'b0;
      szc = (sz < 12) ? 12 : (sz > 32) ? 32 : sz;
      lo = (64'd1 << szc) - 64'd1;
      m_valid[idx] = v; m_size[idx] = szc; m_perm[idx] = p;
      m_base[idx] = b & ~lo[31:0];
   endtask

   // exp < 0 means the model alone supplies the expected code.
   task automatic access(input string req, input logic [31:0] a, input logic [1:0] t,
                         input logic priv, input int exp);
      int mc;
      logic [4:0] es;
      mc = model_code(a, t, priv);
      if (exp >= 0) chk(req, "model", 32'(mc), 32'(exp));
      @(negedge clk);
      acc_req = 1'b1; acc_addr = a; acc_type = t; acc_priv = priv;
      @(negedge clk);
      acc_req = 1'b0;
      es = {mc == 2, (mc == 1) && t == 0, (mc == 3) && t == 0,
            (mc == 1) && t != 0, (mc == 3) && t != 0};
      chk(req, "res_valid", 32'(res_valid), 32'd1);
      chk(req, "res_code", 32'(res_code), 32'(mc));
      chk(req, "strobes", 32'({multi_hit, ins_miss, ins_prot, dat_miss, dat_prot}),
          32'(es));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      for (int e = 0; e < NE; e++) begin
         m_valid[e] = 0; m_base[e] = '0; m_size[e] = 12; m_perm[e] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "res_valid", 32'(res_valid), 32'd0);
      chk("R1", "strobes", 32'({multi_hit, ins_miss, ins_prot, dat_miss, dat_prot}), 32'd0);
      // R1 R3: empty table misses on each side
      access("R3", 32'h0000_4000, 2'd0, 1'b1, 1);
      access("R3", 32'h0000_4000, 2'd1, 1'b1, 1);
      access("R3", 32'h0000_4000, 2'd2, 1'b0, 1);
      // R2: idle cycle after a request
      @(negedge clk);
      chk("R2", "idle res_valid", 32'(res_valid), 32'd0);
      chk("R2", "idle strobes", 32'({multi_hit, ins_miss, ins_prot, dat_miss, dat_prot}), 32'd0);

      // R7 R5 R6: 64 KB region, privileged rwx, unprivileged read only
      wr_entry(0, 32'h1000_0000, 16, 1, 6'b001_111);
      access("R11", 32'h1000_1234, 2'd2, 1'b1, 0);
      access("R5", 32'h1000_1234, 2'd1, 1'b0, 0);
      access("R6", 32'h1000_1234, 2'd2, 1'b0, 3);
      access("R6", 32'h1000_1234, 2'd0, 1'b0, 3);
      access("R7", 32'h1000_1234, 2'd3, 1'b0, 0);
      // R8: region edges
      access("R8", 32'h1000_FFFF, 2'd1, 1'b1, 0);
      access("R8", 32'h1001_0000, 2'd1, 1'b1, 1);
      access("R8", 32'h0FFF_FFFF, 2'd0, 1'b1, 1);
      // R8: size below minimum clamps to 4 KB, base realigned
      wr_entry(1, 32'h2000_0ABC, 3, 1, 6'b111_111);
      access("R8", 32'h2000_0FFF, 2'd1, 1'b0, 0);
      access("R8", 32'h2000_1000, 2'd1, 1'b0, 1);
      // R4: overlap wins over permissions
      wr_entry(2, 32'h1000_8000, 15, 1, 6'b111_111);
      access("R4", 32'h1000_9000, 2'd1, 1'b1, 2);
      access("R4", 32'h1000_9000, 2'd2, 1'b0, 2);
      access("R4", 32'h1000_0100, 2'd2, 1'b0, 3);
      // R10 R11: invalidate entry 2 only
      wr_entry(2, 32'h1000_8000, 15, 0, 6'b111_111);
      access("R10", 32'h1000_9000, 2'd2, 1'b0, 3);
      access("R11", 32'h2000_0004, 2'd0, 1'b0, 0);
      // R9: disabled checking
      chk_en = 1'b0;
      access("R9", 32'h7777_0000, 2'd0, 1'b0, 0);
      access("R9", 32'h1000_9000, 2'd2, 1'b0, 0);
      chk_en = 1'b1;
      // R8: oversized field clamps to the whole space
      wr_entry(3, 32'hDEAD_BEEF, 40, 1, 6'b000_111);
      access("R8", 32'hFFFF_FFF0, 2'd1, 1'b1, 0);
      access("R4", 32'h1000_0000, 2'd1, 1'b1, 2);
      wr_entry(3, 32'h0, 12, 0, 6'b0);

      // Random phase: small address window so regions overlap often
      for (int i = 0; i < 400; i++) begin
         if (i % 8 == 0)
            wr_entry(int'($urandom_range(0, NE-1)), $urandom & 32'h0003_FFFF,
                     int'($urandom_range(10, 18)), $urandom_range(0, 3) != 0,
                     6'($urandom));
         chk_en = ($urandom_range(0, 15) != 0);
         access("R3_R4_R5_R6", $urandom & 32'h0003_FFFF, 2'($urandom),
                1'($urandom), -1);
      end
      chk_en = 1'b1;
      finish_run();
   end

endmodule